// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm Match

This block keeps wall-clock time in four separate fields: a day count, hours, minutes and seconds. An external once-per-second strobe advances them while the run bit in the control register is set. Software sets the time and the alarm through a small 32-bit register bus on which only the low 16 bits carry data. Each write takes effect in the cycle it is issued, so software can read a field back straight away to confirm it.

A pending-event register gathers three kinds of event: the alarm match, the one-second strobe and nine periodic strobes. Software clears a pending bit by writing a one to it. An enable register masks the pending bits, and whatever remains unmasked drives a single interrupt line.

The alarm compare runs once per counted second. It looks at the counters one cycle after they have advanced and sets the alarm event when all four fields equal the alarm registers.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Seconds count 0..59 and then return to 0, carrying into minutes. Minutes count 0..59 and carry into hours. Hours count 0..23 and carry into the day counter. A field at or above its last value rolls to 0 on the next count.
- R3: The day counter is DAY_W bits wide and wraps from all ones to 0.
- R4: Register offsets are 0x00 time hour:minute, 0x04 time seconds, 0x08 alarm hour:minute, 0x0C alarm seconds, 0x10 control, 0x14 pending events, 0x18 event enable, 0x20 day count and 0x24 alarm day. The hour:minute registers hold the hour in bits [12:8] and the minute in bits [5:0]. Seconds are in bits [5:0]. All other bits read 0.
- R5: A write to a time register is visible on the next read exactly as written. If it lands in the same cycle as a counted strobe, the write wins and that second is not counted.
- R6: Pending bit 2 sets one cycle after a counted second whenever day, hour, minute and second all equal the alarm registers.
- R7: Every `tick_1hz` pulse sets pending bit 4. A pulse on `tick_periodic[k]` sets pending bit 7+k. These bits set whatever the run bit holds.
- R8: Writing a one to a pending bit clears it, and writing a zero leaves it unchanged. If the bit's set event arrives in the same cycle as the clear, the bit stays set.
- R9: `irq` is high exactly when some pending bit has its matching enable bit set.
- R10: Control bit 7 is the run bit. While it is 0, strobes do not advance the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| tick_periodic | input | 9 | One-cycle periodic event pulses |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DAY_W=4, so the day counter wraps after sixteen days. A run that starts late on day 15 therefore reaches the all-ones wrap and the alarm match at day 0 within a few hundred strobes. A second sweep of 3700 consecutive seconds from zero passes through every second and minute rollover and into the first hour carry. At each step the bench compares the counters against the day, hour, minute and second values it computes arithmetically from a running second count.

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter #(
  parameter int DAY_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic [8:0]  tick_periodic,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08, A_ASEC = 6'h0C,
                         A_CTL = 6'h10, A_STS = 6'h14, A_IEN = 6'h18, A_DAY = 6'h20,
                         A_ADAY = 6'h24;

  logic [5:0] sec_q, min_q, al_sec, al_min;
  logic [4:0] hr_q, al_hr;
  logic [DAY_W-1:0] day_q, al_day;
  logic [15:0] ctl_q, ien_q, sts_q;
  logic cmp_go;

  wire wr_hm  = bus_wr && bus_addr == A_HM;
  wire wr_sec = bus_wr && bus_addr == A_SEC;
  wire wr_day = bus_wr && bus_addr == A_DAY;
  wire time_wr = wr_hm || wr_sec || wr_day;
  wire tick_go = tick_1hz && ctl_q[7];
  wire sec_end = sec_q >= 6'd59;
  wire min_end = min_q >= 6'd59;
  wire hr_end  = hr_q >= 5'd23;
  wire match = sec_q == al_sec && min_q == al_min && hr_q == al_hr && day_q == al_day;

  wire [15:0] set_vec = {tick_periodic, 2'b00, tick_1hz, 1'b0, cmp_go && match, 2'b00};
  wire [15:0] clr_vec = (bus_wr && bus_addr == A_STS) ? bus_wdata[15:0] : 16'h0;

  assign irq = |(sts_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; day_q <= '0;
      cmp_go <= 1'b0;
    end else begin
      cmp_go <= tick_go;
      if (time_wr) begin
        if (wr_hm) begin
          hr_q  <= bus_wdata[12:8];
          min_q <= bus_wdata[5:0];
        end
        if (wr_sec) sec_q <= bus_wdata[5:0];
        if (wr_day) day_q <= bus_wdata[DAY_W-1:0];
      end else if (tick_go) begin
        sec_q <= sec_end ? '0 : sec_q + 6'd1;
        if (sec_end) min_q <= min_end ? '0 : min_q + 6'd1;
        if (sec_end && min_end) hr_q <= hr_end ? '0 : hr_q + 5'd1;
        if (sec_end && min_end && hr_end) day_q <= day_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec <= '0; al_min <= '0; al_hr <= '0; al_day <= '0;
      ctl_q <= '0; ien_q <= '0; sts_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (bus_wr) begin
        case (bus_addr)
          A_AHM:  begin al_hr <= bus_wdata[12:8]; al_min <= bus_wdata[5:0]; end
          A_ASEC: al_sec <= bus_wdata[5:0];
          A_ADAY: al_day <= bus_wdata[DAY_W-1:0];
          A_CTL:  ctl_q <= bus_wdata[15:0];
          A_IEN:  ien_q <= bus_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_HM:   bus_rdata = {19'd0, hr_q, 2'd0, min_q};
      A_SEC:  bus_rdata = {26'd0, sec_q};
      A_AHM:  bus_rdata = {19'd0, al_hr, 2'd0, al_min};
      A_ASEC: bus_rdata = {26'd0, al_sec};
      A_CTL:  bus_rdata = {16'd0, ctl_q};
      A_STS:  bus_rdata = {16'd0, sts_q};
      A_IEN:  bus_rdata = {16'd0, ien_q};
      A_DAY:  bus_rdata = 32'(day_q);
      A_ADAY: bus_rdata = 32'(al_day);
      default: bus_rdata = '0;
    endcase
  end

  a_r10_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[7] && !time_wr) |=> $stable({day_q, hr_q, min_q, sec_q}));
  a_r6_alarm_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[2]) |-> $past(cmp_go));
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> sts_q[4]);
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 16'h0) |-> !irq);
  a_r3_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && !time_wr && (&day_q) && hr_q == 5'd23 && min_q == 6'd59 && sec_q == 6'd59)
      |=> day_q == '0);
endmodule

// File: tb/test_rtc_alarm_counter.sv
module test_rtc_alarm_counter;
  localparam int DAYS = 16;
  localparam int PERIOD = DAYS * 86400;

  logic clk = 0, rst_n = 0, tick_1hz = 0, bus_wr = 0, irq;
  logic [8:0] tick_periodic = '0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;

  rtc_alarm_counter #(.DAY_W(4)) i_rtc_alarm_counter (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_periodic(tick_periodic),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic tick();
    @(negedge clk) tick_1hz = 1;
    @(negedge clk) tick_1hz = 0;
    @(negedge clk);
  endtask

  task automatic set_time(input int t);
    wr(6'h20, 32'((t / 86400) % DAYS));
    wr(6'h00, 32'((((t / 3600) % 24) << 8) | ((t / 60) % 60)));
    wr(6'h04, 32'(t % 60));
  endtask

  task automatic chk_time(input string req, input int t);
    logic [31:0] d;
    rd(6'h04, d); chk(req, d, 32'(t % 60));
    rd(6'h00, d); chk(req, d, 32'((((t / 3600) % 24) << 8) | ((t / 60) % 60)));
    rd(6'h20, d); chk(req, d, 32'((t / 86400) % DAYS));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t;
    logic [5:0] addrs [9] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h20, 6'h24};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    foreach (addrs[i]) begin rd(addrs[i], d); chk("R1 reset reg", d, 0); end
    chk("R1 irq", 32'(irq), 0);

    wr(6'h00, 32'h0517); rd(6'h00, d); chk("R4 hm pack", d, 32'h0517);
    wr(6'h04, 32'd42);   rd(6'h04, d); chk("R5 sec write", d, 42);
    wr(6'h20, 32'd9);    rd(6'h20, d); chk("R5 day write", d, 9);
    wr(6'h08, 32'h1203); rd(6'h08, d); chk("R4 alarm hm", d, 32'h1203);
    wr(6'h0C, 32'd7);    rd(6'h0C, d); chk("R4 alarm sec", d, 7);
    wr(6'h24, 32'd3);    rd(6'h24, d); chk("R4 alarm day", d, 3);
    wr(6'h18, 32'hFFFF); rd(6'h18, d); chk("R4 enable", d, 32'hFFFF);

    tick();
    rd(6'h00, d); chk("R10 hm held", d, 32'h0517);
    rd(6'h04, d); chk("R10 sec held", d, 42);
    rd(6'h14, d); chk("R7 1hz pending", d, 32'h0010);
    chk("R9 irq set", 32'(irq), 1);
    wr(6'h14, 32'h0); rd(6'h14, d); chk("R8 zero write", d, 32'h0010);
    wr(6'h14, 32'h0010); rd(6'h14, d); chk("R8 clear", d, 0);
    chk("R9 irq clear", 32'(irq), 0);

    for (int k = 0; k < 9; k++) begin
      @(negedge clk) tick_periodic = 9'(1 << k);
      @(negedge clk) tick_periodic = '0;
      rd(6'h14, d); chk("R7 periodic", d, 32'(1 << (7 + k)));
      wr(6'h14, 32'(1 << (7 + k))); rd(6'h14, d); chk("R8 periodic clear", d, 0);
    end

    wr(6'h18, 32'h0);
    @(negedge clk) tick_periodic = 9'h008;
    @(negedge clk) tick_periodic = '0;
    rd(6'h14, d); chk("R7 bit10", d, 32'h0400);
    chk("R9 masked", 32'(irq), 0);
    wr(6'h18, 32'h0400); @(negedge clk); chk("R9 unmasked", 32'(irq), 1);
    wr(6'h14, 32'hFFFF); rd(6'h14, d); chk("R8 clear all", d, 0);
    chk("R9 irq low", 32'(irq), 0);

    @(negedge clk);
    tick_1hz = 1; bus_addr = 6'h14; bus_wdata = 32'h0010; bus_wr = 1;
    @(negedge clk);
    tick_1hz = 0; bus_wr = 0;
    rd(6'h14, d); chk("R8 set wins", d, 32'h0010);
    wr(6'h14, 32'hFFFF);

    wr(6'h10, 32'h0080); rd(6'h10, d); chk("R10 run bit", d, 32'h0080);
    wr(6'h18, 32'h0);
    set_time(10);
    @(negedge clk);
    tick_1hz = 1; bus_addr = 6'h04; bus_wdata = 32'd33; bus_wr = 1;
    @(negedge clk);
    tick_1hz = 0; bus_wr = 0;
    chk_time("R5 write beats tick", 33);

    set_time(0);
    t = 0;
    for (int i = 0; i < 3700; i++) begin
      tick();
      t++;
      chk_time("R2 count", t);
    end

    t = 15 * 86400 + 23 * 3600 + 58 * 60;
    set_time(t);
    wr(6'h24, 32'd0); wr(6'h08, 32'h0000); wr(6'h0C, 32'd30);
    wr(6'h18, 32'h0004);
    wr(6'h14, 32'hFFFF);
    for (int i = 0; i < 200; i++) begin
      tick();
      t = (t + 1) % PERIOD;
      if (t % 86400 == 0) chk_time("R3 day wrap", t);
      rd(6'h14, d);
      chk("R6 alarm pending", 32'(d[2]), 32'(t == 30));
      chk("R9 alarm irq", 32'(irq), 32'(t == 30));
      if (d[2]) begin
        wr(6'h14, 32'h0004); rd(6'h14, d); chk("R8 alarm clear", 32'(d[2]), 0);
      end
    end
    chk_time("R2 after wrap", t);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule